// File: doc/BRIEF.md
# Full-Period Seeded Watermark Sequence Generator

This block produces an 8-bit pseudorandom word stream to use as an image watermark. The sequence comes from a shift register with one-to-many feedback. Each feedback tap passes through a single two-input XOR. An extra term on the feedback path detects when the seven low bits are all clear. That term lets the register pass through the all-zero word instead of sticking there. As a result, the loop covers all 256 values before it repeats.

A secret key is loaded in parallel as the seed. The same key, advanced the same number of times, always gives the same word. This is how the embedder and the detector rebuild one watermark. On every clock the block drives three outputs:

- the registered word;
- a three-level symbol, for additive embedding;
- a single bit, for bit-plane XOR embedding.

Top module: `wm_prng8`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the word to 8'h01.
- R2: With `key_load` high at a rising edge, the word takes the value of `key_in`.
- R3: When `key_load` and `advance` are high at the same edge, the load wins and the word equals `key_in`.
- R4: With `key_load` and `advance` both low, the word holds its value.
- R5: If the low seven bits are not all zero, one advance shifts the word left by one bit. When the old bit 7 was 1, the result is then XORed with 8'h71 (polynomial x^8+x^6+x^5+x^4+1).
- R6: An advance from 8'h80 gives 8'h00. An advance from 8'h00 gives 8'h71.
- R7: From any seed, 256 advances visit each of the 256 words exactly once and return to the seed.
- R8: `wm_trit` equals word bits [1:0], except that code 3 maps to 0. So it only takes the values 0, 1 or 2.
- R9: `wm_bit` equals word bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| key_load | input | 1 | Load `key_in` as the seed; takes priority over `advance` |
| key_in | input | 8 | Watermark key (seed value) |
| advance | input | 1 | Step the sequence by one position |
| wm_word | output | 8 | Current register word |
| wm_trit | output | 2 | Ternary symbol: 0, 1 or 2 |
| wm_bit | output | 1 | Binary watermark bit |

## Verification
The bench walks the full cycle from several keys, including 8'h00 and 8'h80. A design that kept plain XOR feedback would fail here: it would either freeze at zero or skip zero and close the loop after 255 steps. It checks that the step out of 8'h80 lands on zero and that the next step leaves zero for 8'h71. A wrong extension term would repeat a word or break the loop.

It also checks three control corner cases:
- It asserts load and advance together. A design with the wrong priority would come back one step past the key.
- It reloads a key mid-stream and compares the replayed sequence. Any leftover state would make the two runs differ.
- It checks the symbol outputs at every step. A wrong map would let code 3 through.

// File: rtl/wm_prng_pkg.sv
package wm_prng_pkg;

    localparam int WM_W = 8;

    typedef logic [WM_W-1:0] wm_word_t;

    typedef struct packed {
        wm_word_t word;
    } wm_state_t;

endpackage

// File: rtl/wm_lfsr_step.sv
// One-to-many feedback step, extended so the all-zero word is part of the loop.
module wm_lfsr_step
    import wm_prng_pkg::*;
#(
    parameter int       W        = WM_W,
    parameter logic [W-1:0] TAP_MASK = 8'h71
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic low_clear;
    logic fb;

    always_comb begin
        low_clear = ~|cur[W-2:0];
        fb        = cur[W-1] ^ low_clear;
    end

    // Bit 0 gets the feedback term alone; every other bit is its lower
    // neighbour, XORed with the feedback where the polynomial has a tap.
    assign nxt[0] = fb & TAP_MASK[0];

    for (genvar i = 1; i < W; i++) begin : g_tap
        if (TAP_MASK[i]) begin : g_xor
            assign nxt[i] = cur[i-1] ^ fb;
        end else begin : g_pass
            assign nxt[i] = cur[i-1];
        end
    end

    // The only word that leads into zero is the lone MSB.
    always_comb begin
        if (nxt == '0) begin
            AST_ZERO_ENTRY_ONLY: assert (cur == {1'b1, {(W-1){1'b0}}} || $isunknown(cur)); // R6
        end
    end

endmodule

// File: rtl/wm_sym_map.sv
// Derives the ternary symbol and the binary bit from the two low word bits.
module wm_sym_map (
    input  logic [1:0] low_bits,
    output logic [1:0] trit,
    output logic       bin_bit
);

    always_comb begin
        trit    = (low_bits == 2'b11) ? 2'b00 : low_bits;
        bin_bit = low_bits[0];
    end

    always_comb begin
        AST_TRIT_RANGE: assert (trit != 2'b11 || $isunknown(low_bits)); // R8
    end

endmodule

// File: rtl/wm_prng8.sv
module wm_prng8
    import wm_prng_pkg::*;
#(
    parameter logic [WM_W-1:0] TAP_MASK  = 8'h71,
    parameter logic [WM_W-1:0] RESET_KEY = 8'h01
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            key_load,
    input  logic [WM_W-1:0] key_in,
    input  logic            advance,
    output logic [WM_W-1:0] wm_word,
    output logic [1:0]      wm_trit,
    output logic            wm_bit
);

    wm_state_t      st_d, st_q;
    logic [WM_W-1:0] stepped;

    wm_lfsr_step #(
        .W        (WM_W),
        .TAP_MASK (TAP_MASK)
    ) u_step (
        .cur (st_q.word),
        .nxt (stepped)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.word = RESET_KEY;
        end else if (key_load) begin
            st_d.word = key_in;
        end else if (advance) begin
            st_d.word = stepped;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wm_word = st_q.word;

    wm_sym_map u_sym (
        .low_bits (st_q.word[1:0]),
        .trit     (wm_trit),
        .bin_bit  (wm_bit)
    );

    AST_RESET_KEY: assert property (@(posedge clk)
        rst |=> (wm_word == RESET_KEY)); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        key_load |=> (wm_word == $past(key_in))); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!key_load && !advance) |=> $stable(wm_word)); // R4

    AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!key_load && advance && wm_word == '0) |=> (wm_word == TAP_MASK)); // R6

    AST_TOP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!key_load && advance && wm_word == {1'b1, {(WM_W-1){1'b0}}}) |=> (wm_word == '0)); // R6

    AST_BIT_MATCH: assert property (@(posedge clk) disable iff (rst)
        wm_bit == wm_word[0]); // R9

endmodule

// File: tb/wm_prng8_test.sv
module wm_prng8_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       key_load;
    logic [7:0] key_in;
    logic       advance;
    logic [7:0] wm_word;
    logic [1:0] wm_trit;
    logic       wm_bit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wm_prng8 uut (
        .clk      (clk),
        .rst      (rst),
        .key_load (key_load),
        .key_in   (key_in),
        .advance  (advance),
        .wm_word  (wm_word),
        .wm_trit  (wm_trit),
        .wm_bit   (wm_bit)
    );

    // Multiply by x modulo x^8+x^6+x^5+x^4+1, with zero spliced after 8'h80.
    function automatic logic [7:0] ref_next(input logic [7:0] v);
        logic [8:0] t;
        if (v == 8'h80) return 8'h00;
        if (v == 8'h00) return 8'h71;
        t = {v, 1'b0};
        if (t[8]) t = t ^ 9'h171;
        return t[7:0];
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_syms(input logic [7:0] w);
        logic [1:0] et;
        et = (w[1:0] == 2'b11) ? 2'b00 : w[1:0];
        check8("R8", {6'd0, wm_trit}, {6'd0, et});
        check8("R9", {7'd0, wm_bit}, {7'd0, w[0]});
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic cycle(input logic ld, input logic [7:0] k, input logic adv);
        key_load = ld;
        key_in   = k;
        advance  = adv;
        @(negedge clk);
        key_load = 1'b0;
        advance  = 1'b0;
    endtask

    task automatic full_loop(input logic [7:0] seed);
        bit seen [256];
        logic [7:0] exp;
        int dup;
        int miss;
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        cycle(1'b1, seed, 1'b0);
        check8("R2", wm_word, seed);
        exp = seed;
        dup = 0;
        for (int s = 0; s < 256; s++) begin
            if (seen[wm_word]) dup++;
            seen[wm_word] = 1'b1;
            cycle(1'b0, 8'h00, 1'b1);
            exp = ref_next(exp);
            check8((exp[6:0] == 7'd0 || exp == 8'h71) ? "R6" : "R5", wm_word, exp);
            check_syms(wm_word);
        end
        miss = 0;
        for (int i = 0; i < 256; i++) if (!seen[i]) miss++;
        check8("R7 duplicates", dup[7:0], 8'd0);
        check8("R7 missing", miss[7:0], 8'd0);
        check8("R7 return", wm_word, seed);
    endtask

    initial begin
        logic [7:0] rec [16];
        logic [7:0] held;
        rst = 1'b1; key_load = 1'b0; key_in = 8'h00; advance = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check8("R1", wm_word, 8'h01);
        check_syms(wm_word);

        // Reset dominates a load in the same cycle.
        rst = 1'b1;
        cycle(1'b1, 8'hCC, 1'b1);
        rst = 1'b0;
        check8("R1", wm_word, 8'h01);

        full_loop(8'h01);
        full_loop(8'hA5);
        full_loop(8'h00);
        full_loop(8'h80);

        // Zero splice in isolation.
        cycle(1'b1, 8'h80, 1'b0);
        cycle(1'b0, 8'h00, 1'b1);
        check8("R6", wm_word, 8'h00);
        cycle(1'b0, 8'h00, 1'b1);
        check8("R6", wm_word, 8'h71);

        // Load beats advance.
        cycle(1'b1, 8'h3C, 1'b0);
        cycle(1'b1, 8'h5A, 1'b1);
        check8("R3", wm_word, 8'h5A);

        // Idle holds.
        held = wm_word;
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, 8'hFF, 1'b0);
            check8("R4", wm_word, held);
        end

        // Same key and step count replay the same words.
        cycle(1'b1, 8'h9E, 1'b0);
        for (int i = 0; i < 16; i++) begin
            cycle(1'b0, 8'h00, 1'b1);
            rec[i] = wm_word;
        end
        for (int i = 0; i < 7; i++) cycle(1'b0, 8'h00, 1'b1);
        cycle(1'b1, 8'h9E, 1'b0);
        check8("R2", wm_word, 8'h9E);
        for (int i = 0; i < 16; i++) begin
            cycle(1'b0, 8'h00, 1'b1);
            check8("R2 replay", wm_word, rec[i]);
        end

        // Symbol map for every low-bit code.
        for (int c = 0; c < 4; c++) begin
            cycle(1'b1, {6'b101100, c[1:0]}, 1'b0);
            check_syms({6'b101100, c[1:0]});
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule